// File: doc/BRIEF.md
# Event Record Format Checker

This block watches a byte stream that carries event records and checks the framing of each record as it goes past. A record opens with a twelve-byte header. After the header come a number of objects that all have the same length, then a four-byte logical trailer, then zero bytes that fill the record out to a sixteen-byte boundary. The block keeps the header fields it decodes and works out where the trailer has to begin from the counts the header declares. It then checks that the trailer repeats the header's bunch and data-type identifiers, that the two parity bytes in the trailer match, that the padding is all zeros, and that the total length is correct.

Bytes arrive one per clock, qualified by a valid flag. The first byte of a record carries a start strobe and the last byte carries an end strobe. One cycle after the end byte, the block raises a one-cycle done pulse. At that point the decoded fields and six separate error flags can be read, and they stay as they are until the next record starts. The block does not hold or forward the payload. A start strobe in the middle of a record drops that record and begins a new one.

Top module: `evr_checker`

## Requirements
- R1: While reset is held and on the first cycle after it, `rec_done`, every error flag and every field output read zero.
- R2: Header byte index 0 is the object count. Index 1 is the header length in 4-byte words. Index 2 is the object length in 4-byte words. In index 3, bits 7:5 are the header format and bits 4:0 are the object format. Index 4 is the data type and index 5 is the bunch number. Indices 6 and 7 are the rotation number, least significant byte first. In index 11, bit 7 is the error mark and bit 0 is the simulated-data mark. The fields keep their values once the header is complete and are valid while `rec_done` is high.
- R3: `rec_done` is high for exactly the cycle that follows a valid byte carrying `rx_eof` inside a record. It is never high at any other time.
- R4: The trailer offset is 4×(header words) + 4×(object words)×(object count), counted from the first header byte. `err_bunch` is set when the byte at the offset differs from header byte 5.
- R5: `err_dtype` is set when the byte at offset+1 differs from header byte 4.
- R6: `err_even_par` is set when the byte at offset+2 differs from the XOR of all bytes that have an even index and lie below the offset.
- R7: `err_odd_par` is set when the byte at offset+3 differs from the XOR of all bytes that have an odd index and lie below the offset.
- R8: `err_length` is set when any of these holds: the record is shorter than 12 bytes; the header word count is below 3; the record ends before offset+4; the record runs past offset+4 rounded up to a multiple of 16; or the length lies outside 16 to 4096 bytes.
- R9: `err_padding` is set when the record length is not a multiple of 16, or when any byte at or after offset+4 (and at index 12 or above) is non-zero.
- R10: The flags of R4 to R7 read zero whenever the header is incomplete or malformed, or the record ends before the trailer has been fully received.
- R11: Valid bytes outside a record, and beats with `rx_valid` low, change no output. A start strobe in the middle of a record discards that record and restarts decoding at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Stream byte |
| rx_valid | input | 1 | Byte qualifier |
| rx_sof | input | 1 | First byte of a record (with rx_valid) |
| rx_eof | input | 1 | Last byte of a record (with rx_valid) |
| rec_done | output | 1 | One-cycle pulse after the last byte |
| obj_count | output | 8 | Declared object count |
| hdr_words | output | 8 | Header length in 4-byte words |
| obj_words | output | 8 | Object length in 4-byte words |
| hdr_fmt | output | 3 | Header/trailer format number |
| obj_fmt | output | 5 | Object format number |
| data_type | output | 8 | Data type identifier |
| bunch_id | output | 8 | Bunch number |
| rotation | output | 16 | Rotation number |
| stat_error | output | 1 | Status error mark |
| stat_sim | output | 1 | Simulated-data mark |
| err_bunch | output | 1 | Trailer bunch mismatch |
| err_dtype | output | 1 | Trailer data-type mismatch |
| err_even_par | output | 1 | Even-lane parity mismatch |
| err_odd_par | output | 1 | Odd-lane parity mismatch |
| err_length | output | 1 | Length or header-size error |
| err_padding | output | 1 | Padding or alignment error |

## Verification
A wrong byte index or a stale trailer offset does not show up until the record closes. It then appears one cycle after the end byte, as one flag wrongly set or wrongly clear, so every record has to be compared at its done pulse. A parity lane that takes the wrong bytes only shows in the parity flags, so those records carry payloads with varied byte values. A mid-record restart or a stray byte that leaks into the state shows up in the fields and flags of the following record. Leftover sticky state would look the same, so records that corrupt one byte are followed by clean records.

// File: rtl/evr_pkg.sv
package evr_pkg;

    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned WORD_SHIFT    = 2;
    localparam int unsigned HDR_BYTES     = 12;
    localparam int unsigned TRL_BYTES     = 4;
    localparam int unsigned MIN_HDR_WORDS = 3;

    // header byte positions decoded by the capture stage
    localparam int unsigned POS_COUNT  = 0;
    localparam int unsigned POS_HWORDS = 1;
    localparam int unsigned POS_OWORDS = 2;
    localparam int unsigned POS_FMT    = 3;
    localparam int unsigned POS_DTYPE  = 4;
    localparam int unsigned POS_BUNCH  = 5;
    localparam int unsigned POS_ROT_LO = 6;
    localparam int unsigned POS_ROT_HI = 7;
    localparam int unsigned POS_STATUS = 11;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t       count;
        byte_t       hdr_words;
        byte_t       obj_words;
        logic [2:0]  hdr_fmt;
        logic [4:0]  obj_fmt;
        byte_t       dtype;
        byte_t       bunch;
        logic [15:0] rotation;
        logic        st_err;
        logic        st_sim;
    } evr_fields_t;

    typedef struct packed {
        logic bunch;
        logic dtype;
        logic even;
        logic odd;
        logic len;
        logic pad;
    } evr_errs_t;

endpackage

// File: rtl/evr_hdr_capture.sv
module evr_hdr_capture
    import evr_pkg::*;
#(
    parameter int unsigned IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            data,
    output evr_fields_t      fields
);

    evr_fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (beat) begin
            if (sof) begin
                f_d = '0;
            end
            case (idx)
                IDX_W'(POS_COUNT):  f_d.count     = data;
                IDX_W'(POS_HWORDS): f_d.hdr_words = data;
                IDX_W'(POS_OWORDS): f_d.obj_words = data;
                IDX_W'(POS_FMT): begin
                    f_d.hdr_fmt = data[7:5];
                    f_d.obj_fmt = data[4:0];
                end
                IDX_W'(POS_DTYPE):  f_d.dtype           = data;
                IDX_W'(POS_BUNCH):  f_d.bunch           = data;
                IDX_W'(POS_ROT_LO): f_d.rotation[7:0]   = data;
                IDX_W'(POS_ROT_HI): f_d.rotation[15:8]  = data;
                IDX_W'(POS_STATUS): begin
                    f_d.st_err = data[7];
                    f_d.st_sim = data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fields = f_q;

    AST_HDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !sof && idx >= IDX_W'(HDR_BYTES)) |=> $stable(f_q))
        else $error("header fields moved after header end"); // R2

    AST_HDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && sof) |=> (f_q.count == $past(data) && f_q.bunch == '0 && f_q.dtype == '0))
        else $error("start strobe did not restart capture"); // R11

endmodule

// File: rtl/evr_lane_parity.sv
module evr_lane_parity
    import evr_pkg::*;
#(
    parameter int unsigned IDX_W = 14,
    parameter int unsigned OFF_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            data,
    input  logic [OFF_W-1:0] toff,
    output byte_t            even_acc,
    output byte_t            odd_acc
);

    localparam int unsigned LANES = 2;

    logic  take;
    byte_t lane_acc [LANES];

    always_comb begin
        take = (idx < IDX_W'(HDR_BYTES)) || (OFF_W'(idx) < toff);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_t acc_d, acc_q;

        always_comb begin
            acc_d = acc_q;
            if (beat) begin
                if (sof) begin
                    acc_d = '0;
                end
                if (take && (idx[0] == 1'(g))) begin
                    acc_d = acc_d ^ data;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_d;
            end
        end

        assign lane_acc[g] = acc_q;
    end

    assign even_acc = lane_acc[0];
    assign odd_acc  = lane_acc[1];

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !sof && idx >= IDX_W'(HDR_BYTES) && OFF_W'(idx) >= toff)
        |=> ($stable(even_acc) && $stable(odd_acc)))
        else $error("parity moved at or past the trailer"); // R6

    AST_PAR_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !sof && !idx[0]) |=> $stable(odd_acc))
        else $error("even-index byte reached odd lane"); // R7

endmodule

// File: rtl/evr_trailer_check.sv
module evr_trailer_check
    import evr_pkg::*;
#(
    parameter int unsigned IDX_W       = 14,
    parameter int unsigned OFF_W       = 19,
    parameter int unsigned ALIGN_BYTES = 16,
    parameter int unsigned MIN_LEN     = 16,
    parameter int unsigned MAX_LEN     = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sof,
    input  logic             eof,
    input  logic [IDX_W-1:0] idx,
    input  byte_t            data,
    input  logic [OFF_W-1:0] toff,
    input  byte_t            hdr_words,
    input  byte_t            dtype,
    input  byte_t            bunch,
    input  byte_t            even_acc,
    input  byte_t            odd_acc,
    output logic             done,
    output evr_errs_t        errs
);

    localparam logic [OFF_W-1:0] ALIGN_MASK = OFF_W'(ALIGN_BYTES - 1);

    typedef struct packed {
        logic      s_bunch;
        logic      s_dtype;
        logic      s_even;
        logic      s_odd;
        logic      s_pad;
        logic      done;
        evr_errs_t errs;
    } chk_t;

    chk_t             c_d, c_q;
    logic [OFF_W-1:0] tend, pad_end, pos, rlen;
    logic             in_body, hdr_ok, whole;

    always_comb begin
        tend    = toff + OFF_W'(TRL_BYTES);
        pad_end = (tend + ALIGN_MASK) & ~ALIGN_MASK;
        pos     = OFF_W'(idx);
        rlen    = pos + OFF_W'(1);
        in_body = idx >= IDX_W'(HDR_BYTES);
        hdr_ok  = (idx >= IDX_W'(HDR_BYTES - 1)) && (hdr_words >= BYTE_W'(MIN_HDR_WORDS));
        whole   = hdr_ok && (rlen >= tend);

        c_d      = c_q;
        c_d.done = 1'b0;
        if (beat) begin
            if (sof) begin
                c_d.s_bunch = 1'b0;
                c_d.s_dtype = 1'b0;
                c_d.s_even  = 1'b0;
                c_d.s_odd   = 1'b0;
                c_d.s_pad   = 1'b0;
            end
            if (in_body) begin
                if (pos == toff && data != bunch) begin
                    c_d.s_bunch = 1'b1;
                end
                if (pos == toff + OFF_W'(1) && data != dtype) begin
                    c_d.s_dtype = 1'b1;
                end
                if (pos == toff + OFF_W'(2) && data != even_acc) begin
                    c_d.s_even = 1'b1;
                end
                if (pos == toff + OFF_W'(3) && data != odd_acc) begin
                    c_d.s_odd = 1'b1;
                end
                if (pos >= tend && data != '0) begin
                    c_d.s_pad = 1'b1;
                end
            end
            if (eof) begin
                c_d.done       = 1'b1;
                c_d.errs.len   = !hdr_ok || (rlen < tend) || (rlen > pad_end) ||
                                 (rlen < OFF_W'(MIN_LEN)) || (rlen > OFF_W'(MAX_LEN));
                c_d.errs.pad   = ((rlen & ALIGN_MASK) != '0) || c_d.s_pad;
                c_d.errs.bunch = whole && c_d.s_bunch;
                c_d.errs.dtype = whole && c_d.s_dtype;
                c_d.errs.even  = whole && c_d.s_even;
                c_d.errs.odd   = whole && c_d.s_odd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done = c_q.done;
    assign errs = c_q.errs;

    AST_SHORT_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && eof && idx < IDX_W'(HDR_BYTES - 1))
        |=> (errs.len && !errs.bunch && !errs.dtype && !errs.even && !errs.odd))
        else $error("trailer flag on a record without header"); // R10

    AST_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && eof && OFF_W'(idx) >= OFF_W'(MAX_LEN)) |=> errs.len)
        else $error("oversize record not flagged"); // R8

endmodule

// File: rtl/evr_checker.sv
module evr_checker
    import evr_pkg::*;
#(
    parameter int unsigned ALIGN_BYTES = 16,
    parameter int unsigned MIN_LEN     = 16,
    parameter int unsigned MAX_LEN     = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    output logic        rec_done,
    output logic [7:0]  obj_count,
    output logic [7:0]  hdr_words,
    output logic [7:0]  obj_words,
    output logic [2:0]  hdr_fmt,
    output logic [4:0]  obj_fmt,
    output logic [7:0]  data_type,
    output logic [7:0]  bunch_id,
    output logic [15:0] rotation,
    output logic        stat_error,
    output logic        stat_sim,
    output logic        err_bunch,
    output logic        err_dtype,
    output logic        err_even_par,
    output logic        err_odd_par,
    output logic        err_length,
    output logic        err_padding
);

    localparam int unsigned IDX_W = $clog2(MAX_LEN + ALIGN_BYTES) + 1;
    localparam int unsigned OFF_W = 2 * BYTE_W + WORD_SHIFT + 1;
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(ALIGN_BYTES - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             beat;
    logic [IDX_W-1:0] idx_cur;
    logic [OFF_W-1:0] toff;
    evr_fields_t      fields;
    evr_errs_t        errs;
    byte_t            even_acc, odd_acc;
    logic             done;

    always_comb begin
        beat    = rx_valid && (rx_sof || ctl_q.active);
        idx_cur = rx_sof ? '0 : ctl_q.idx;
        ctl_d   = ctl_q;
        if (beat) begin
            ctl_d.active = !rx_eof;
            ctl_d.idx    = (idx_cur == '1) ? idx_cur : idx_cur + IDX_W'(1);
        end
        toff = (OFF_W'(fields.hdr_words) << WORD_SHIFT) +
               ((OFF_W'(fields.obj_words) * OFF_W'(fields.count)) << WORD_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    evr_hdr_capture #(
        .IDX_W (IDX_W)
    ) u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat   (beat),
        .sof    (rx_sof),
        .idx    (idx_cur),
        .data   (rx_byte),
        .fields (fields)
    );

    evr_lane_parity #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .sof      (rx_sof),
        .idx      (idx_cur),
        .data     (rx_byte),
        .toff     (toff),
        .even_acc (even_acc),
        .odd_acc  (odd_acc)
    );

    evr_trailer_check #(
        .IDX_W       (IDX_W),
        .OFF_W       (OFF_W),
        .ALIGN_BYTES (ALIGN_BYTES),
        .MIN_LEN     (MIN_LEN),
        .MAX_LEN     (MAX_LEN)
    ) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .sof       (rx_sof),
        .eof       (rx_eof),
        .idx       (idx_cur),
        .data      (rx_byte),
        .toff      (toff),
        .hdr_words (fields.hdr_words),
        .dtype     (fields.dtype),
        .bunch     (fields.bunch),
        .even_acc  (even_acc),
        .odd_acc   (odd_acc),
        .done      (done),
        .errs      (errs)
    );

    assign rec_done     = done;
    assign obj_count    = fields.count;
    assign hdr_words    = fields.hdr_words;
    assign obj_words    = fields.obj_words;
    assign hdr_fmt      = fields.hdr_fmt;
    assign obj_fmt      = fields.obj_fmt;
    assign data_type    = fields.dtype;
    assign bunch_id     = fields.bunch;
    assign rotation     = fields.rotation;
    assign stat_error   = fields.st_err;
    assign stat_sim     = fields.st_sim;
    assign err_bunch    = errs.bunch;
    assign err_dtype    = errs.dtype;
    assign err_even_par = errs.even;
    assign err_odd_par  = errs.odd;
    assign err_length   = errs.len;
    assign err_padding  = errs.pad;

    AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> $past(rx_valid && rx_eof))
        else $error("done without a closing byte"); // R3

    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.active && !(rx_valid && rx_sof)) |=> !rec_done)
        else $error("done outside a record"); // R11

    AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && !err_length) |->
        ($past(idx_cur) >= IDX_W'(MIN_LEN - 1) && $past(idx_cur) <= IDX_W'(MAX_LEN - 1)))
        else $error("length outside window accepted"); // R8

    AST_PAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_done && !err_padding) |-> (($past(idx_cur) & IDX_MASK) == IDX_MASK))
        else $error("unaligned record accepted"); // R9

endmodule

// File: tb/sim_evr_checker.sv
module sim_evr_checker;

    typedef struct {
        bit          hc;
        bit          whole;
        logic [7:0]  cnt, hw, ow, dt, bn;
        logic [2:0]  hf;
        logic [4:0]  of;
        logic [15:0] rot;
        bit          se, ss;
        bit          eb, ed, ee, eo, el, ep;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;

    logic        rec_done, stat_error, stat_sim;
    logic [7:0]  obj_count, hdr_words, obj_words, data_type, bunch_id;
    logic [2:0]  hdr_fmt;
    logic [4:0]  obj_fmt;
    logic [15:0] rotation;
    logic        err_bunch, err_dtype, err_even_par, err_odd_par, err_length, err_padding;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;
    bit chk_en   = 0;

    logic [7:0] mq[$];
    logic [7:0] rec[$];
    bit   m_active = 0;
    bit   nxt_done = 0, exp_done = 0;
    exp_t nxt_e, cur_e;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    evr_checker u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rec_done(rec_done),
        .obj_count(obj_count), .hdr_words(hdr_words), .obj_words(obj_words),
        .hdr_fmt(hdr_fmt), .obj_fmt(obj_fmt), .data_type(data_type),
        .bunch_id(bunch_id), .rotation(rotation), .stat_error(stat_error),
        .stat_sim(stat_sim), .err_bunch(err_bunch), .err_dtype(err_dtype),
        .err_even_par(err_even_par), .err_odd_par(err_odd_par),
        .err_length(err_length), .err_padding(err_padding)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    function automatic logic [7:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    // behavioural model of one closed record
    function automatic exp_t evaluate();
        exp_t e;
        int L, hw, T, P, toff;
        logic [7:0] xe, xo;
        e = '{default: 0};
        L = mq.size();
        e.hc = (L >= 12);
        T = 0; P = 0; toff = 0; hw = 0;
        if (e.hc) begin
            e.cnt = mq[0]; e.hw = mq[1]; e.ow = mq[2];
            e.hf = mq[3][7:5]; e.of = mq[3][4:0];
            e.dt = mq[4]; e.bn = mq[5]; e.rot = {mq[7], mq[6]};
            e.se = mq[11][7]; e.ss = mq[11][0];
            hw = int'(mq[1]);
            toff = 4 * hw + 4 * int'(mq[2]) * int'(mq[0]);
            T = toff + 4;
            P = ((T + 15) / 16) * 16;
        end
        e.el = !e.hc || hw < 3 || L < T || L > P || L < 16 || L > 4096;
        e.whole = e.hc && hw >= 3 && L >= T;
        if (e.whole) begin
            xe = 0; xo = 0;
            for (int i = 0; i < toff; i++) begin
                if (i % 2 == 0) xe ^= mq[i]; else xo ^= mq[i];
            end
            e.eb = mq[toff] != mq[5];
            e.ed = mq[toff + 1] != mq[4];
            e.ee = mq[toff + 2] != xe;
            e.eo = mq[toff + 3] != xo;
        end
        e.ep = (L % 16) != 0;
        if (e.hc) begin
            for (int i = 12; i < L; i++) begin
                if (i >= T && mq[i] != 0) e.ep = 1;
            end
        end
        return e;
    endfunction

    task automatic beat(input logic [7:0] b, input bit v, input bit sof, input bit eof);
        @(posedge clk);
        #1;
        rx_byte = b; rx_valid = v; rx_sof = sof; rx_eof = eof;
        nxt_done = 0;
        if (v && (sof || m_active)) begin
            if (sof) mq.delete();
            mq.push_back(b);
            m_active = !eof;
            if (eof) begin
                nxt_e = evaluate();
                nxt_done = 1;
            end
        end
    endtask

    task automatic idle();
        beat(8'h00, 0, 0, 0);
    endtask

    function automatic int trl_off(input int cnt, input int hw, input int ow);
        return 4 * hw + 4 * ow * cnt;
    endfunction

    task automatic make_rec(input int cnt, input int hw, input int ow, input logic [7:0] fmt,
                            input logic [7:0] dt, input logic [7:0] bn, input logic [15:0] rot,
                            input logic [7:0] status);
        logic [7:0] xe, xo;
        rec.delete();
        rec.push_back(8'(cnt)); rec.push_back(8'(hw)); rec.push_back(8'(ow));
        rec.push_back(fmt); rec.push_back(dt); rec.push_back(bn);
        rec.push_back(rot[7:0]); rec.push_back(rot[15:8]);
        rec.push_back(8'h07); rec.push_back(8'h01); rec.push_back(8'hA5);
        rec.push_back(status);
        for (int i = 12; i < 4 * hw; i++) rec.push_back(8'h3C);
        for (int i = 0; i < 4 * ow * cnt; i++) rec.push_back(rnd());
        xe = 0; xo = 0;
        for (int i = 0; i < rec.size(); i++) begin
            if (i % 2 == 0) xe ^= rec[i]; else xo ^= rec[i];
        end
        rec.push_back(bn); rec.push_back(dt); rec.push_back(xe); rec.push_back(xo);
        while (rec.size() % 16 != 0) rec.push_back(8'h00);
    endtask

    task automatic send_rec(input bit gaps, input bit close);
        for (int i = 0; i < rec.size(); i++) begin
            if (gaps && (i % 5 == 2)) beat(8'hEE, 0, 0, 0);
            beat(rec[i], 1, i == 0, i == rec.size() - 1);
        end
        if (close) idle();
        repeat (2) idle();
    endtask

    always @(posedge clk) begin
        exp_done = nxt_done;
        cur_e    = nxt_e;
    end

    always @(negedge clk) begin
        if (chk_en) begin
            check("R3", "rec_done", 32'(rec_done), 32'(exp_done));
            if (exp_done) begin
                check(cur_e.whole ? "R4" : "R10", "err_bunch", 32'(err_bunch), 32'(cur_e.eb));
                check(cur_e.whole ? "R5" : "R10", "err_dtype", 32'(err_dtype), 32'(cur_e.ed));
                check(cur_e.whole ? "R6" : "R10", "err_even_par", 32'(err_even_par), 32'(cur_e.ee));
                check(cur_e.whole ? "R7" : "R10", "err_odd_par", 32'(err_odd_par), 32'(cur_e.eo));
                check("R8", "err_length", 32'(err_length), 32'(cur_e.el));
                check("R9", "err_padding", 32'(err_padding), 32'(cur_e.ep));
                if (cur_e.hc) begin
                    check("R2", "obj_count", 32'(obj_count), 32'(cur_e.cnt));
                    check("R2", "hdr_words", 32'(hdr_words), 32'(cur_e.hw));
                    check("R2", "obj_words", 32'(obj_words), 32'(cur_e.ow));
                    check("R2", "hdr_fmt", 32'(hdr_fmt), 32'(cur_e.hf));
                    check("R2", "obj_fmt", 32'(obj_fmt), 32'(cur_e.of));
                    check("R2", "data_type", 32'(data_type), 32'(cur_e.dt));
                    check("R2", "bunch_id", 32'(bunch_id), 32'(cur_e.bn));
                    check("R2", "rotation", 32'(rotation), 32'(cur_e.rot));
                    check("R2", "stat_error", 32'(stat_error), 32'(cur_e.se));
                    check("R2", "stat_sim", 32'(stat_sim), 32'(cur_e.ss));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "rec_done in reset", 32'(rec_done), 0);
        check("R1", "flags in reset", 32'({err_bunch, err_dtype, err_even_par, err_odd_par, err_length, err_padding}), 0);
        check("R1", "fields in reset", 32'({obj_count, hdr_words, obj_words, data_type}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "fields after reset", 32'({bunch_id, rotation, stat_error, stat_sim}), 0);
        chk_en = 1;

        // clean records, several shapes
        make_rec(3, 3, 2, 8'h25, 8'h11, 8'h42, 16'hBEEF, 8'h81); send_rec(0, 1);
        make_rec(0, 3, 1, 8'hE3, 8'h22, 8'h07, 16'h0102, 8'h00); send_rec(0, 1);
        make_rec(2, 5, 1, 8'h41, 8'h33, 8'h99, 16'hCAFE, 8'h01); send_rec(1, 1);

        // R4..R7: single corrupted trailer bytes
        for (int k = 0; k < 4; k++) begin
            make_rec(3, 3, 2, 8'h25, 8'h44, 8'h5A, 16'h1357, 8'h00);
            t = trl_off(3, 3, 2);
            rec[t + k] = rec[t + k] ^ 8'h10;
            send_rec(0, 1);
            make_rec(1, 3, 3, 8'h25, 8'h45, 8'h5B, 16'h2468, 8'h00); send_rec(0, 1);
        end

        // R9: non-zero padding byte
        make_rec(3, 3, 2, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00);
        rec[47] = 8'h01; send_rec(0, 1);

        // R8: short record ending before the trailer
        make_rec(3, 3, 2, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00);
        while (rec.size() > 32) void'(rec.pop_back());
        send_rec(0, 1);

        // R8: record running a full group past its padded end
        make_rec(3, 3, 2, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00);
        for (int i = 0; i < 16; i++) rec.push_back(8'h00);
        send_rec(0, 1);

        // R9: record ending off the alignment
        make_rec(3, 3, 2, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00);
        repeat (4) void'(rec.pop_back());
        send_rec(0, 1);

        // R10: truncated header, malformed header word count
        make_rec(3, 3, 2, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00);
        while (rec.size() > 8) void'(rec.pop_back());
        send_rec(0, 1);
        make_rec(1, 2, 1, 8'h25, 8'h12, 8'h34, 16'h0000, 8'h00); send_rec(0, 1);

        // R11: restart in the middle of a record
        make_rec(3, 3, 2, 8'h25, 8'h66, 8'h77, 16'h0000, 8'h00);
        for (int i = 0; i < 20; i++) beat(rec[i], 1, i == 0, 0);
        make_rec(2, 3, 1, 8'h25, 8'h68, 8'h79, 16'hABCD, 8'h00); send_rec(0, 1);
        @(negedge clk);
        check("R11", "count after restart", 32'(obj_count), 2);

        // R11: stray bytes outside any record change nothing
        for (int i = 0; i < 6; i++) beat(8'hF0 + 8'(i), 1, 0, i == 5);
        idle();
        @(negedge clk);
        check("R11", "done after stray bytes", 32'(rec_done), 0);
        check("R11", "count after stray bytes", 32'(obj_count), 2);
        check("R11", "flags after stray bytes", 32'({err_length, err_padding}), 0);

        // back-to-back: clean record then a one-byte record
        make_rec(1, 3, 1, 8'h25, 8'h13, 8'h24, 16'h0000, 8'h00);
        for (int i = 0; i < rec.size(); i++) beat(rec[i], 1, i == 0, i == rec.size() - 1);
        beat(8'h05, 1, 1, 1);
        repeat (3) idle();

        // R8: largest legal record and one past the maximum
        make_rec(255, 3, 4, 8'h25, 8'h55, 8'hAA, 16'h7777, 8'h80); send_rec(0, 1);
        make_rec(255, 7, 4, 8'h25, 8'h56, 8'hAB, 16'h8888, 8'h00); send_rec(0, 1);

        repeat (4) idle();
        report();
        $finish;
    end

endmodule